// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block sits between a two-wire serial bus (a clock line and a bidirectional open-drain data line) and a small byte-addressed memory. It samples both bus lines with the system clock and recognises bus start and stop conditions. After a start it takes in a slave address byte. If the device identifier and the three pin-strapped select bits both match, it acknowledges the byte and then either receives a word address and data to write, or streams stored bytes back to the bus master.

The block never drives the data line high. It only asserts a pull-low enable, which the pad ring turns into an open-drain driver. On the memory side it presents a synchronous port: an address, write data, a one-cycle write enable, and read data that the memory returns for the presented address. An internal address counter steps after every byte moved in either direction, so sequential reads and writes run through the 4096-byte space and wrap.

A repeated start at any point abandons the current byte and begins address reception again. This supports the usual random-read sequence: write the word address, restart, then read. A stop always returns the block to an idle standby state.

Top module: `twi_mem_slave`

## Requirements
- R1: After reset the pull-low enable `sdaPullLow` is 0 and `memWe` is 0.
- R2: Until a start condition (data line falling while the clock line is high) has been seen, clocked bytes get no acknowledge and cause no memory write.
- R3: The slave address byte is, MSB first, the identifier 1010, then three select bits that must equal `selStrap`, then a direction bit in bit 0 (1 = read). The block acknowledges the byte (data line held low through the ninth clock pulse) only if both the identifier and the select bits match. On any mismatch it gives no acknowledge and ignores the bus until the next start.
- R4: In a write transfer every following byte is acknowledged. The first two are the word address, high byte first. The low four bits of the high byte form address bits 11..8, and the second byte forms bits 7..0.
- R5: Each data byte received after the word address produces exactly one single-cycle `memWe` pulse, with `memAddr` at the current counter value and `memWdata` equal to the byte. The counter then steps by one and wraps from 0xFFF to 0x000.
- R6: In a read transfer the block sends the byte at the current counter address, MSB first. While the master acknowledges, it keeps sending the next byte, and the counter steps once per byte sent, wrapping from 0xFFF to 0x000.
- R7: When the master does not acknowledge a read byte, the block releases the data line and drives nothing on later clock pulses until a start or stop.
- R8: A stop condition (data line rising while the clock line is high) ends any transfer. Bytes clocked after it without a new start are ignored.
- R9: A repeated start received in the middle of any byte aborts that byte and restarts slave address reception. A write-then-restart-then-read sequence reads from the address just written.
- R10: `sdaPullLow` changes only while the clock line is low. Received bits are taken on the rising edge of the clock line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| selStrap | input | 3 | Pin-strapped select value compared against the address byte |
| sdaPullLow | output | 1 | Active-high enable that pulls the data line low |
| memAddr | output | 12 | Memory byte address (the address counter) |
| memWdata | output | 8 | Byte to write |
| memWe | output | 1 | One-cycle write strobe |
| memRdata | input | 8 | Byte the memory holds at `memAddr` |

## Verification
The bench aims at the address byte. It uses a wrong select field and a wrong identifier. A design that compared only part of the byte would acknowledge one of these and go on to write memory. It clocks bytes before any start and after a stop, where a block that does not gate on the start would acknowledge them. It aborts a data byte halfway with a repeated start. A design that kept its bit count across the restart would misalign every later byte and write to the wrong address. It also runs the counter across the top of the address space in both directions, where a missing wrap would show up as wrong write addresses or wrong read bytes. After a read is not acknowledged, it clocks one more byte and expects the line to stay released, all ones.

// File: rtl/twi_slave_pkg.sv
package twi_slave_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_AHI, ST_ALO, ST_WDATA, ST_RDATA, ST_WAIT
  } twi_state_t;

  // bus events found by the datapath, one cycle wide
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
    logic sdaBit;
  } twi_event_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic loadHi;
    logic loadLo;
    logic incAddr;
    logic writeMem;
    logic setAck;
    logic loadTx;
    logic shiftTx;
    logic relSda;
  } twi_strobe_t;

endpackage

// File: rtl/twi_slave_dp.sv
module twi_slave_dp
  import twi_slave_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  twi_strobe_t       stb,
  input  logic [7:0]        memRdata,
  output twi_event_t        ev,
  output logic [7:0]        rxByte,
  output logic [ADDR_W-1:0] addrCnt,
  output logic              sdaOut
);
  localparam int HI_W = ADDR_W - 8;

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclD, sdaD;
  logic [6:0] txRest;

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];

  // idle bus is high, so reset the pipes high to avoid false events
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclD    <= sclS;
      sdaD    <= sdaS;
    end
  end

  always_comb begin
    ev.sclRise   = sclS & ~sclD;
    ev.sclFall   = ~sclS & sclD;
    ev.startSeen = sclS & sclD & sdaD & ~sdaS;
    ev.stopSeen  = sclS & sclD & ~sdaD & sdaS;
    ev.sdaBit    = sdaS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte  <= '0;
      addrCnt <= '0;
      txRest  <= '0;
      sdaOut  <= 1'b0;
    end else begin
      if (stb.shiftIn) rxByte <= {rxByte[6:0], sdaS};
      if (stb.loadHi) addrCnt[ADDR_W-1:8] <= rxByte[HI_W-1:0];
      else if (stb.loadLo) addrCnt[7:0] <= rxByte;
      else if (stb.incAddr) addrCnt <= addrCnt + ADDR_W'(1);
      if (stb.relSda) sdaOut <= 1'b0;
      else if (stb.setAck) sdaOut <= 1'b1;
      else if (stb.loadTx) begin
        sdaOut <= ~memRdata[7];
        txRest <= memRdata[6:0];
      end else if (stb.shiftTx) begin
        sdaOut <= ~txRest[6];
        txRest <= {txRest[5:0], 1'b0};
      end
    end
  end

endmodule

// File: rtl/twi_slave_ctrl.sv
module twi_slave_ctrl
  import twi_slave_pkg::*;
#(
  parameter logic [3:0] DEV_ID = 4'b1010
) (
  input  logic        clk,
  input  logic        rstN,
  input  twi_event_t  ev,
  input  logic [7:0]  rxByte,
  input  logic [2:0]  selStrap,
  output twi_strobe_t stb
);
  localparam logic [3:0] BYTE_BITS = 4'd8;
  localparam logic [3:0] ACK_SEEN  = 4'd9;

  twi_state_t state, stNext;
  logic [3:0] bitCnt, cntNext;
  logic       inAck, ackNext;
  logic       devMatch;

  assign devMatch = (rxByte[7:1] == {DEV_ID, selStrap});

  always_comb begin
    stb     = '0;
    stNext  = state;
    cntNext = bitCnt;
    ackNext = inAck;
    if (ev.stopSeen || ev.startSeen) begin
      stNext     = ev.stopSeen ? ST_IDLE : ST_DEV;
      cntNext    = '0;
      ackNext    = 1'b0;
      stb.relSda = 1'b1;
    end else begin
      case (state)
        ST_DEV, ST_AHI, ST_ALO, ST_WDATA: begin
          if (!inAck) begin
            if (ev.sclRise && bitCnt < BYTE_BITS) begin
              stb.shiftIn = 1'b1;
              cntNext     = bitCnt + 4'd1;
            end else if (ev.sclFall && bitCnt == BYTE_BITS) begin
              if (state == ST_DEV && !devMatch) begin
                stNext  = ST_IDLE;
                cntNext = '0;
              end else begin
                stb.setAck   = 1'b1;
                ackNext      = 1'b1;
                stb.loadHi   = (state == ST_AHI);
                stb.loadLo   = (state == ST_ALO);
                stb.writeMem = (state == ST_WDATA);
                stb.incAddr  = (state == ST_WDATA);
              end
            end
          end else if (ev.sclFall) begin
            ackNext = 1'b0;
            cntNext = '0;
            if (state == ST_DEV && rxByte[0]) begin
              stb.loadTx = 1'b1;
              stNext     = ST_RDATA;
            end else begin
              stb.relSda = 1'b1;
              case (state)
                ST_DEV:  stNext = ST_AHI;
                ST_AHI:  stNext = ST_ALO;
                default: stNext = ST_WDATA;
              endcase
            end
          end
        end
        ST_RDATA: begin
          if (!inAck) begin
            if (ev.sclRise && bitCnt < BYTE_BITS) cntNext = bitCnt + 4'd1;
            else if (ev.sclFall && bitCnt == BYTE_BITS) begin
              stb.relSda = 1'b1;
              ackNext    = 1'b1;
            end else if (ev.sclFall && bitCnt != 4'd0) stb.shiftTx = 1'b1;
          end else begin
            if (ev.sclRise && bitCnt == BYTE_BITS) begin
              stb.incAddr = 1'b1;
              if (ev.sdaBit) begin
                stNext  = ST_WAIT;
                ackNext = 1'b0;
                cntNext = '0;
              end else cntNext = ACK_SEEN;
            end else if (ev.sclFall && bitCnt == ACK_SEEN) begin
              stb.loadTx = 1'b1;
              cntNext    = '0;
              ackNext    = 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      inAck  <= 1'b0;
    end else begin
      state  <= stNext;
      bitCnt <= cntNext;
      inAck  <= ackNext;
    end
  end

endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
  import twi_slave_pkg::*;
#(
  parameter int         ADDR_W      = 12,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_ID      = 4'b1010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [2:0]        selStrap,
  output logic              sdaPullLow,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic              memWe,
  input  logic [7:0]        memRdata
);
  twi_event_t  ev;
  twi_strobe_t stb;
  logic [7:0]  rxByte;

  twi_slave_dp #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .stb(stb),
    .memRdata(memRdata), .ev(ev), .rxByte(rxByte), .addrCnt(memAddr),
    .sdaOut(sdaPullLow)
  );

  twi_slave_ctrl #(.DEV_ID(DEV_ID)) uCtrl (
    .clk(clk), .rstN(rstN), .ev(ev), .rxByte(rxByte),
    .selStrap(selStrap), .stb(stb)
  );

  assign memWdata = rxByte;
  assign memWe    = stb.writeMem;

endmodule

// File: rtl/twi_mem_slave_chk.sv
module twi_mem_slave_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclIn,
  input logic              sdaPullLow,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr
);
  // R5: a written byte is acknowledged right away
  assert_write_acked_R5: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> sdaPullLow);

  // R5: counter steps after each write, wrapping at the top
  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> memAddr == $past(memAddr) + ADDR_W'(1));

  // R5: write strobe lasts a single cycle
  assert_we_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> !memWe);

  // R10: pull-low enable only moves while the clock line is low
  assert_sda_moves_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPullLow) |-> !sclIn);

endmodule

bind twi_mem_slave twi_mem_slave_chk #(.ADDR_W(ADDR_W)) uChk (.*);

// File: tb/tb_twi_mem_slave.sv
module tb_twi_mem_slave;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic [2:0] selStrap = 3'b101;
  logic sdaPullLow, memWe;
  logic [11:0] memAddr;
  logic [7:0] memWdata, memRdata;
  wire sdaLine = sdaM & ~sdaPullLow;

  logic [7:0] mem [4096];
  logic [7:0] refMem [4096];
  logic [19:0] expQ[$];
  int nChecks = 0;
  int nFail = 0;
  logic sclAtPos = 1'b1;
  logic prevPull = 1'b0;

  always #5 clk = ~clk;

  twi_mem_slave dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .selStrap(selStrap),
    .sdaPullLow(sdaPullLow), .memAddr(memAddr), .memWdata(memWdata),
    .memWe(memWe), .memRdata(memRdata)
  );

  assign memRdata = mem[memAddr];
  always @(posedge clk) begin
    if (memWe) mem[memAddr] <= memWdata;
    sclAtPos <= sclM;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compare each write strobe against the queue
  always @(negedge clk) begin
    if (rstN && memWe) begin
      if (expQ.size() == 0) check(1'b0, "R5 unexpected write", {memAddr, memWdata}, 0);
      else begin
        logic [19:0] e;
        e = expQ.pop_front();
        check({memAddr, memWdata} == e, "R5 write item", {memAddr, memWdata}, e);
      end
    end
    if (rstN && sdaPullLow !== prevPull)
      check(sclAtPos == 1'b0, "R10 pull changed with clock high", sclAtPos, 0);
    prevPull = sdaPullLow;
  end

  task automatic hq(); repeat (8) @(negedge clk); endtask

  task automatic busStart();
    sclM = 1'b0; hq(); sdaM = 1'b1; hq(); sclM = 1'b1; hq();
    sdaM = 1'b0; hq(); sclM = 1'b0; hq();
  endtask

  task automatic busStop();
    sclM = 1'b0; hq(); sdaM = 1'b0; hq(); sclM = 1'b1; hq(); sdaM = 1'b1; hq();
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    sclM = 1'b0; hq();
    for (int i = 7; i > 7 - n; i--) begin
      sdaM = b[i]; hq(); sclM = 1'b1; hq(); sclM = 1'b0; hq();
    end
  endtask

  task automatic writeByte(input logic [7:0] b, output bit acked);
    sendBits(b, 8);
    sdaM = 1'b1; hq(); sclM = 1'b1;
    repeat (4) @(negedge clk);
    acked = !sdaLine;
    repeat (4) @(negedge clk);
    sclM = 1'b0; hq();
  endtask

  task automatic readByte(input bit giveAck, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hq(); sclM = 1'b1;
      repeat (4) @(negedge clk);
      b[i] = sdaLine;
      repeat (4) @(negedge clk);
      sclM = 1'b0;
    end
    hq(); sdaM = giveAck ? 1'b0 : 1'b1; hq(); sclM = 1'b1; hq(); sclM = 1'b0; hq();
    sdaM = 1'b1;
  endtask

  // driver: sets the word address then writes bytes, pushing expectations
  task automatic writeSeq(input logic [11:0] a, input logic [7:0] d0, input logic [7:0] d1,
                          input int n);
    bit ak;
    logic [11:0] p;
    busStart();
    writeByte(8'hAA, ak); check(ak, "R3 matching address acked", ak, 1);
    writeByte({4'h0, a[11:8]}, ak); check(ak, "R4 high address acked", ak, 1);
    writeByte(a[7:0], ak); check(ak, "R4 low address acked", ak, 1);
    p = a;
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      d = (k == 0) ? d0 : d1 + 8'(k);
      expQ.push_back({p, d});
      refMem[p] = d;
      writeByte(d, ak); check(ak, "R4 data byte acked", ak, 1);
      p = p + 12'd1;
    end
  endtask

  task automatic randomRead(input logic [11:0] a, input int n);
    bit ak;
    logic [7:0] b;
    busStart();
    writeByte(8'hAA, ak);
    writeByte({4'h0, a[11:8]}, ak);
    writeByte(a[7:0], ak);
    busStart();
    writeByte(8'hAB, ak); check(ak, "R9 read address acked after restart", ak, 1);
    for (int k = 0; k < n; k++) begin
      logic [11:0] p;
      p = a + 12'(k);
      readByte(k != n - 1, b);
      check(b == refMem[p], "R6 read byte", b, refMem[p]);
    end
  endtask

  initial begin
    bit ak;
    logic [7:0] b;
    for (int i = 0; i < 4096; i++) begin mem[i] = 8'h00; refMem[i] = 8'h00; end
    repeat (3) @(negedge clk);
    check(sdaPullLow == 1'b0, "R1 pull low at reset", sdaPullLow, 0);
    check(memWe == 1'b0, "R1 write strobe at reset", memWe, 0);
    rstN = 1'b1; hq();

    writeByte(8'hAA, ak); check(!ak, "R2 byte before start", ak, 0);
    writeByte(8'h55, ak); check(!ak, "R2 second byte before start", ak, 0);

    writeSeq(12'h123, 8'h11, 8'h21, 3);
    busStop();

    busStart(); writeByte(8'hA2, ak); check(!ak, "R3 wrong select", ak, 0);
    writeByte(8'h00, ak); check(!ak, "R3 ignored after mismatch", ak, 0);
    busStart(); writeByte(8'hBA, ak); check(!ak, "R3 wrong identifier", ak, 0);
    busStop();

    randomRead(12'h123, 3);
    readByte(1'b0, b); check(b == 8'hFF, "R7 no drive after missing ack", b, 8'hFF);
    busStop();

    writeSeq(12'hFFF, 8'h5A, 8'hA4, 2);
    busStop();
    randomRead(12'hFFF, 2);
    busStop();

    writeByte(8'hAA, ak); check(!ak, "R8 byte after stop ignored", ak, 0);
    writeByte(8'h7E, ak); check(!ak, "R8 second byte after stop", ak, 0);

    busStart();
    writeByte(8'hAA, ak); writeByte(8'h02, ak); writeByte(8'h00, ak);
    sendBits(8'hC3, 4);
    writeSeq(12'h300, 8'h77, 8'h00, 1);
    busStop();
    randomRead(12'h300, 1);
    busStop();
    check(mem[12'h200] == 8'h00, "R9 aborted byte not written", mem[12'h200], 0);

    hq();
    check(expQ.size() == 0, "R5 all writes seen", expQ.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule